// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Front-End

This block is the bus-facing side of a simple serial port. A processor reaches four word-sized registers through a single-cycle strobe interface: receive data, transmit data, status and control. Bytes from a serial receiver arrive on a byte-stream input with a valid/ready pair and are queued in an eight-entry circular receive queue. Reading the receive-data register returns the oldest queued byte and removes it in the same access. Writing the transmit-data register passes its low byte to a serial transmitter as a one-cycle strobe. No transmit queue is modelled, so the transmit side always reports empty.

A sticky pending flag records that the queue holds data or that a transmit write took place. The interrupt output is that flag gated by an enable bit in the control register. Writing control can flush the receive queue. Such a write also clears the pending flag if the queue is empty afterwards.

Bus reads are combinational. Read data is valid during the cycle the strobe is high, and any side effects take place at the end of that cycle. When a bus access and an incoming byte fall in the same cycle, the access is handled first and the byte second.

Top module: `uart_regfront`

## Requirements
- R1: The register index is byte address bits [3:2]. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control.
- R2: The status word is defined bit by bit:
  - bit0 is 1 when the queue holds at least one byte.
  - bit1 is 1 when the queue holds 8 bytes.
  - bit2 always reads 1.
  - bit4 is the pending flag.
  - bits 3, 5, 6, 7 and all bits above 7 read 0.
- R3: A read of index 0 returns the oldest queued byte, zero-extended, and removes it. A read of an empty queue does not decrement the occupancy.
- R4: While the queue holds 8 bytes, rx_ready is low and an arriving byte is discarded.
- R5: A control write with bit1 set empties the queue and resets its write position. The full 32-bit value written to control is stored and reads back.
- R6: A control write with bit1 clear leaves the queue contents and occupancy unchanged, including when bit0 is set.
- R7: The pending flag is set when the queue is non-empty after a cycle or when index 1 is written. It is cleared by a control write with bit0 or bit1 set, but only if the queue is then empty.
- R8: irq equals the pending flag AND control bit4.
- R9: A write to index 1 stores the 32-bit value for readback. In the next cycle it puts the low 8 bits on tx_byte with tx_valid high for exactly one cycle.
- R10: Writes to index 2 and index 0 change no state.
- R11: After reset:
  - the queue is empty and its storage reads as zero;
  - the control and transmit registers are zero;
  - the pending flag is clear and irq is low;
  - status reads 0x04.
- R12: A receive-data read and an incoming byte in the same cycle return the oldest byte and also queue the new one. The occupancy is then unchanged.
- R13: The queue position wraps after the eighth slot, so byte order is kept across more than 8 total bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can accept a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest states to reach are the full queue with a ninth byte offered and a pop coinciding with a push. The stimulus creates both by driving rx_valid directly, independently of rx_ready. It also issues a receive-data read in the same cycle as a byte. Wrap-around is reached by draining a full queue and then pushing and popping unequal runs, so that the write position crosses slot 7. The pending-flag clear is tested both with an empty queue and with a non-empty one, to separate the two outcomes.

// File: rtl/uart_regfront_pkg.sv
// Package: shared register indices and bit positions of the serial port
// register front-end. Assumes a 16-byte word-addressed window.
package uart_regfront_pkg;

    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_idx_e;

    // status word bit positions
    localparam int ST_RXVAL   = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;
    localparam int ST_OVR     = 5;
    localparam int ST_FRM     = 6;
    localparam int ST_PAR     = 7;

    // control word bit positions
    localparam int CT_TXCLR = 0;
    localparam int CT_RXCLR = 1;
    localparam int CT_IE    = 4;

    // register index position inside the byte address
    localparam int IDX_LSB = 2;

endpackage

// File: rtl/uart_rxq.sv
// Module: circular receive byte queue with occupancy counter.
// Assumes: at most one push and one pop per cycle; a clear takes effect
// before a same-cycle push, so that byte lands in slot 0. A pop of an
// empty queue leaves the count alone. Pushes are accepted only while
// in_ready is high.
module uart_rxq #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              pop_req,
    input  logic              clr,
    output logic [BYTE_W-1:0] head_byte,
    output logic [CNT_W-1:0]  fill,
    output logic [CNT_W-1:0]  fill_next
);

    localparam int SUM_W = PTR_W + CNT_W + 1;

    logic [BYTE_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [CNT_W-1:0]  fill_q;
    logic              accept;
    logic              pop_ok;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  wptr_inc;
    logic [PTR_W-1:0]  rd_idx;
    logic [SUM_W-1:0]  rd_sum;

    assign in_ready = (fill_q != CNT_W'(DEPTH));
    assign accept   = in_valid && in_ready;
    assign pop_ok   = pop_req && (fill_q != '0);
    assign wr_idx   = clr ? '0 : wptr_q;
    assign fill     = fill_q;

    // next write position with wrap at the last slot
    assign wptr_inc = (wr_idx == PTR_W'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;

    // oldest entry sits fill_q slots behind the write position
    always_comb begin
        rd_sum = SUM_W'(wptr_q) + SUM_W'(DEPTH) - SUM_W'(fill_q);
        if (rd_sum >= SUM_W'(DEPTH)) begin
            rd_sum = rd_sum - SUM_W'(DEPTH);
        end
        rd_idx = rd_sum[PTR_W-1:0];
    end

    assign head_byte = slot_q[rd_idx];

    // occupancy after this cycle's clear, pop and push
    always_comb begin
        if (clr) begin
            fill_next = CNT_W'(accept);
        end else begin
            fill_next = fill_q + CNT_W'(accept) - CNT_W'(pop_ok);
        end
    end

    // pointer and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            fill_q <= '0;
        end else begin
            fill_q <= fill_next;
            if (accept) begin
                wptr_q <= wptr_inc;
            end else if (clr) begin
                wptr_q <= '0;
            end
        end
    end

    // byte storage, one slot per entry
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                end else if (accept && (wr_idx == PTR_W'(g))) begin
                    slot_q[g] <= in_byte;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/uart_pend.sv
// Module: sticky pending flag and gated interrupt level.
// Assumes: rx_nz_next reflects the queue occupancy after the current
// cycle, so a clear does not drop the flag while data remains.
module uart_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_hit,
    input  logic ctrl_clr_hit,
    input  logic rx_nz_next,
    input  logic ie,
    output logic pend,
    output logic irq
);

    logic pend_q;

    // set on queued data or transmit write, clear on qualifying control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (ctrl_clr_hit && !rx_nz_next) begin
            pend_q <= 1'b0;
        end else if (tx_hit || rx_nz_next) begin
            pend_q <= 1'b1;
        end
    end

    assign pend = pend_q;
    assign irq  = pend_q && ie;

endmodule

// File: rtl/uart_txport.sv
// Module: transmit data register and outgoing byte strobe.
// Assumes: the downstream transmitter takes one byte per strobe with no
// back-pressure, so every write produces one strobe cycle.
module uart_txport #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [DATA_W-1:0] word_q;
    logic              stb_q;
    logic [BYTE_W-1:0] byte_q;

    // hold the last written word and raise a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            stb_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            stb_q <= wr_hit;
            if (wr_hit) begin
                word_q <= wdata;
                byte_q <= wdata[BYTE_W-1:0];
            end
        end
    end

    assign tx_word  = word_q;
    assign tx_valid = stb_q;
    assign tx_byte  = byte_q;

endmodule

// File: rtl/uart_regfront.sv
// Module: register front-end of a simple serial port. Decodes a 16-byte
// word-addressed window, owns the control register, builds the status
// word and muxes read data.
// Assumes: single-cycle strobes; read data is combinational and valid
// while bus_sel is high; side effects land at the closing clock edge.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 8,
    localparam int BYTE_W = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    reg_idx_e          idx;
    logic              wr_stb;
    logic              rd_stb;
    logic              rxd_rd;
    logic              txd_wr;
    logic              ctrl_wr;
    logic              ctrl_clr_hit;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] stat_word;
    logic [BYTE_W-1:0] head_byte;
    logic [CNT_W-1:0]  fill_cnt;
    logic [CNT_W-1:0]  fill_next;
    logic              pend_q;

    // address decode
    assign idx     = reg_idx_e'(bus_addr[IDX_LSB +: 2]);
    assign wr_stb  = bus_sel && bus_wr;
    assign rd_stb  = bus_sel && !bus_wr;
    assign rxd_rd  = rd_stb && (idx == REG_RXD);
    assign txd_wr  = wr_stb && (idx == REG_TXD);
    assign ctrl_wr = wr_stb && (idx == REG_CTRL);
    assign ctrl_clr_hit = ctrl_wr && (bus_wdata[CT_TXCLR] || bus_wdata[CT_RXCLR]);

    uart_rxq #(
        .DEPTH  (DEPTH),
        .BYTE_W (BYTE_W)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_byte   (rx_byte),
        .in_ready  (rx_ready),
        .pop_req   (rxd_rd),
        .clr       (ctrl_wr && bus_wdata[CT_RXCLR]),
        .head_byte (head_byte),
        .fill      (fill_cnt),
        .fill_next (fill_next)
    );

    uart_pend u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_hit       (txd_wr),
        .ctrl_clr_hit (ctrl_clr_hit),
        .rx_nz_next   (fill_next != '0),
        .ie           (ctrl_q[CT_IE]),
        .pend         (pend_q),
        .irq          (irq)
    );

    uart_txport #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (txd_wr),
        .wdata    (bus_wdata),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    // control register holds the whole written word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata;
        end
    end

    // status word from live queue state and the pending flag
    always_comb begin
        stat_word             = '0;
        stat_word[ST_RXVAL]   = (fill_cnt != '0);
        stat_word[ST_RXFULL]  = (fill_cnt == CNT_W'(DEPTH));
        stat_word[ST_TXEMPTY] = 1'b1;
        stat_word[ST_TXFULL]  = 1'b0;
        stat_word[ST_PEND]    = pend_q;
        stat_word[ST_OVR]     = 1'b0;
        stat_word[ST_FRM]     = 1'b0;
        stat_word[ST_PAR]     = 1'b0;
    end

    // read data mux
    always_comb begin
        case (idx)
            REG_RXD:  bus_rdata = DATA_W'(head_byte);
            REG_TXD:  bus_rdata = tx_word;
            REG_STAT: bus_rdata = stat_word;
            default:  bus_rdata = ctrl_q;
        endcase
    end

endmodule

// File: rtl/uart_regfront_chk.sv
// Module: property checker bound to the register front-end.
module uart_regfront_chk #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wdata_rxclr,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              irq,
    input logic [CNT_W-1:0]  fill,
    input logic              pend,
    input logic              ie
);

    logic rxd_rd_c;
    logic clr_c;
    logic txw_c;
    assign rxd_rd_c = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd0);
    assign clr_c    = bus_sel && bus_wr && (bus_addr[3:2] == 2'd3) && bus_wdata_rxclr;
    assign txw_c    = bus_sel && bus_wr && (bus_addr[3:2] == 2'd1);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH) && rx_valid && !rxd_rd_c && !clr_c)
        |=> fill == CNT_W'(DEPTH));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && rxd_rd_c && !rx_valid) |=> fill == '0);

    // R5
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_c |=> fill <= CNT_W'(1));

    // R7
    fill_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |-> pend);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ie));

    // R9
    tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txw_c |=> tx_valid);

    // R4
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (fill == CNT_W'(DEPTH)));

endmodule

bind uart_regfront uart_regfront_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata_rxclr (bus_wdata[1]),
    .rx_valid        (rx_valid),
    .rx_ready        (rx_ready),
    .tx_valid        (tx_valid),
    .irq             (irq),
    .fill            (fill_cnt),
    .pend            (pend_q),
    .ie              (ctrl_q[4])
);

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rd_cap;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_regfront u_uart_regfront (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );

    // vector: op[1:0] (0 read-compare, 1 write, 2 push), addr[3:0], data, expected
    localparam logic [69:0] VEC [NVEC] = '{
        {2'd0, 4'h8, 32'h0,         32'h0000_0004},
        {2'd2, 4'h0, 32'h11,        32'h0},
        {2'd2, 4'h0, 32'h22,        32'h0},
        {2'd0, 4'h8, 32'h0,         32'h0000_0015},
        {2'd0, 4'h0, 32'h0,         32'h0000_0011},
        {2'd0, 4'h0, 32'h0,         32'h0000_0022},
        {2'd0, 4'h8, 32'h0,         32'h0000_0014},
        {2'd1, 4'hC, 32'h13,        32'h0},
        {2'd0, 4'hC, 32'h0,         32'h0000_0013},
        {2'd0, 4'h8, 32'h0,         32'h0000_0004},
        {2'd1, 4'h4, 32'hA5A5_1234, 32'h0},
        {2'd0, 4'h4, 32'h0,         32'hA5A5_1234},
        {2'd0, 4'h8, 32'h0,         32'h0000_0014},
        {2'd1, 4'h8, 32'hFF,        32'h0},
        {2'd0, 4'h8, 32'h0,         32'h0000_0014},
        {2'd1, 4'h0, 32'h77,        32'h0},
        {2'd0, 4'h8, 32'h0,         32'h0000_0014},
        {2'd1, 4'hC, 32'h01,        32'h0},
        {2'd0, 4'h8, 32'h0,         32'h0000_0004},
        {2'd0, 4'hC, 32'h0,         32'h0000_0001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; rx_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; rx_valid = 1'b0;
        #1 rd_cap = bus_rdata;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b1; rx_byte = b;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R11 reset state
        check("R11 rx_ready", 32'(rx_ready), 32'd1);
        check("R11 irq", 32'(irq), 32'd0);
        check("R11 tx_valid", 32'(tx_valid), 32'd0);
        rd(4'h0); check("R11 empty rx read", rd_cap, 32'h0);
        rd(4'h4); check("R11 tx reg", rd_cap, 32'h0);
        rd(4'hC); check("R11 ctrl reg", rd_cap, 32'h0);

        // vector walk: R1 R2 R3 R5 R7 R10 decode and status
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][69:68])
                2'd0: begin
                    rd(VEC[i][67:64]);
                    check($sformatf("R1/R2 vector %0d", i), rd_cap, VEC[i][31:0]);
                end
                2'd1: wr(VEC[i][67:64], VEC[i][63:32]);
                default: push(VEC[i][39:32]);
            endcase
        end
        idle();

        // R4 fill, overflow drop
        for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
        idle();
        check("R4 ready low when full", 32'(rx_ready), 32'd0);
        push(8'h48);
        rd(4'h8); check("R2 full status", rd_cap, 32'h17);
        for (int i = 0; i < 8; i++) begin
            rd(4'h0); check("R4 drain order", rd_cap, 32'h40 + 32'(i));
        end
        rd(4'h8); check("R4 ninth byte dropped", rd_cap, 32'h14);

        // R13 wrap across slot 7
        for (int i = 0; i < 5; i++) push(8'h60 + 8'(i));
        for (int i = 0; i < 5; i++) begin
            rd(4'h0); check("R13 first run", rd_cap, 32'h60 + 32'(i));
        end
        for (int i = 0; i < 6; i++) push(8'h70 + 8'(i));
        for (int i = 0; i < 6; i++) begin
            rd(4'h0); check("R13 wrapped run", rd_cap, 32'h70 + 32'(i));
        end

        // R3 empty read does not underflow
        rd(4'h0);
        push(8'h5A);
        rd(4'h0); check("R3 after empty read", rd_cap, 32'h5A);
        rd(4'h8); check("R3 empty again", rd_cap, 32'h14);

        // R12 pop and push together
        push(8'h90);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0; rx_valid = 1'b1; rx_byte = 8'h91;
        #1 rd_cap = bus_rdata;
        check("R12 oldest returned", rd_cap, 32'h90);
        rd(4'h8); check("R12 one entry left", rd_cap, 32'h15);
        rd(4'h0); check("R12 new byte queued", rd_cap, 32'h91);

        // R6 control bit0 alone keeps queue; R7 flag held while data remains
        push(8'h33);
        wr(4'hC, 32'h01);
        rd(4'h8); check("R6 R7 queue and flag kept", rd_cap, 32'h15);
        rd(4'h0); check("R6 byte intact", rd_cap, 32'h33);

        // R5 clear a non-empty queue
        push(8'hA1); push(8'hA2);
        wr(4'hC, 32'hDEAD_0002);
        rd(4'hC); check("R5 ctrl stored", rd_cap, 32'hDEAD_0002);
        rd(4'h8); check("R5 R7 cleared", rd_cap, 32'h04);
        push(8'h66);
        rd(4'h0); check("R5 restart at new byte", rd_cap, 32'h66);

        // R8 interrupt gating
        wr(4'hC, 32'h12); idle();
        check("R8 irq low after clear", 32'(irq), 32'd0);
        wr(4'h4, 32'h0);  idle();
        check("R8 irq on tx write", 32'(irq), 32'd1);
        wr(4'hC, 32'h00); idle();
        check("R8 irq masked", 32'(irq), 32'd0);
        wr(4'hC, 32'h10); idle();
        check("R8 irq unmasked", 32'(irq), 32'd1);
        wr(4'hC, 32'h11); idle();
        check("R8 irq after flag clear", 32'(irq), 32'd0);
        push(8'h01); idle();
        check("R8 irq on rx data", 32'(irq), 32'd1);
        rd(4'h0); idle();

        // R9 transmit strobe timing
        wr(4'h4, 32'h0000_01C3);
        #1 check("R9 no strobe before edge", 32'(tx_valid), 32'd0);
        idle();
        check("R9 strobe high", 32'(tx_valid), 32'd1);
        check("R9 tx byte", 32'(tx_byte), 32'hC3);
        idle();
        check("R9 strobe one cycle", 32'(tx_valid), 32'd0);

        // R10 ignored writes leave no strobe or data
        wr(4'h0, 32'h55); idle();
        check("R10 rx write no strobe", 32'(tx_valid), 32'd0);
        rd(4'h8); check("R10 rx write no data", rd_cap[0] ? 32'd1 : 32'd0, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule